// File: doc/BRIEF.md
# Translation-Pointer Cache Tag Array

This block is the tag store of a set-associative, write-through first-level data cache. A way does not hold a physical address tag. It holds a one-hot pointer into the translation buffer, naming the buffer entry that translates the line, together with a valid bit. A lookup compares against the translation buffer's match vector for the current access, not against an address. A way hits when it is valid and its pointer bit coincides with a set bit of that match vector. The compare is therefore a wide AND followed by an OR, with no equality compare.

Two read ports work independently and in parallel. Each port takes a set index and a match vector, and returns a per-way hit vector in the same cycle. It also raises a flag when more than one way hits. A fill port writes a way's pointer and makes the way valid. A line-drop port invalidates one way. When the translation buffer replaces entry k, a retire input clears bit k in every stored pointer, so lines that were mapped through k can no longer hit.

Each stored pointer is checked for more than one set bit. A corrupted way of this kind never hits, and is flagged on the port that reads it. It is invalidated at the next clock edge. Write-through makes that invalidation safe, because no dirty data can be lost.

Top module: `xtag_array`

## Requirements
- R1: After reset no way of any of the 64 sets is valid: every hit, multi-hit and corrupt output is 0 for any read. A fill of set s, way w with vector v stores v and makes the way valid from the next clock edge on. A later fill replaces the earlier vector.
- R2: In the same cycle as its inputs, read port p drives rd_hit bit p*4+w to 1 exactly when way w of the addressed set is valid, its stored vector has at most one bit set, and the AND of the stored vector with rd_match is nonzero. Port p's set index is rd_set[6p+5:6p] and its match vector is rd_match[32p+31:32p].
- R3: The two read ports are independent. Each port's outputs depend only on its own set index and match vector, even when the two ports address different sets in the same cycle.
- R4: rd_multi_hit[p] is 1 exactly when two or more bits of port p's hit slice are 1.
- R5: When a valid way read by port p holds a vector with more than one bit set, rd_corrupt bit p*4+w is 1 and the hit bit for that way is 0, whatever the match vector.
- R6: A way flagged corrupt on any port is invalidated at the next clock edge. Afterwards it neither hits nor flags until it is filled again.
- R7: A pulse on xlat_retire_en with index k clears bit k of every stored vector at the next edge. Other bits and the valid bits are unchanged.
- R8: A fill wins over a same-edge line drop, corrupt invalidation or retire that targets the same set and way. The filled vector is stored unmodified, and the way is valid.
- R9: A pulse on line_drop_en invalidates the addressed set and way at the next edge. Other ways are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write a pointer vector into one way |
| fill_set | input | 6 | Set written by a fill |
| fill_way | input | 2 | Way written by a fill |
| fill_vec | input | 32 | One-hot translation pointer to store |
| line_drop_en | input | 1 | Invalidate one way |
| line_drop_set | input | 6 | Set of the way to invalidate |
| line_drop_way | input | 2 | Way to invalidate |
| xlat_retire_en | input | 1 | A translation entry is being replaced |
| xlat_retire_idx | input | 5 | Index of the replaced translation entry |
| rd_set | input | 12 | Set index per read port, port p at [6p+5:6p] |
| rd_match | input | 64 | Translation match vector per port, port p at [32p+31:32p] |
| rd_hit | output | 8 | Per-way hit, port p way w at bit p*4+w |
| rd_multi_hit | output | 2 | More than one way hit on port p |
| rd_corrupt | output | 8 | Multi-hot stored vector seen, port p way w at bit p*4+w |

## Verification
A wrong stored vector or valid bit shows up at rd_hit in the first cycle a port reads that set, because the lookup is combinational. A lost retire shows up as a hit on a match vector holding only the retired bit. A missing corrupt invalidation shows up one cycle after the flag, as a flag that persists or as a hit after a clean refill elsewhere. Each scenario reads the affected set and its neighbouring ways right after the edge that should have changed them.

// File: rtl/xtag_pkg.sv
package xtag_pkg;
   // width of an index over n items, at least one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/xtag_way_cmp.sv
module xtag_way_cmp #(
   parameter int unsigned XE         = 32,
   parameter bit          ONEHOT_CHK = 1'b1
) (
   input  logic [XE-1:0] vec,
   input  logic          vld,
   input  logic [XE-1:0] match,
   output logic          hit,
   output logic          corrupt
);
   logic multi;

   generate
      if (ONEHOT_CHK) begin : g_chk
         // more than one bit set: clearing the lowest set bit leaves something
         assign multi = |(vec & (vec - XE'(1)));
      end else begin : g_nochk
         assign multi = 1'b0;
      end
   endgenerate

   assign corrupt = vld & multi;
   assign hit     = vld & ~multi & (|(vec & match));
endmodule

// File: rtl/xtag_rd_port.sv
module xtag_rd_port #(
   parameter int unsigned SETS       = 64,
   parameter int unsigned WAYS       = 4,
   parameter int unsigned XE         = 32,
   parameter bit          ONEHOT_CHK = 1'b1,
   localparam int unsigned IDX_W     = xtag_pkg::idx_w(SETS)
) (
   input  logic [IDX_W-1:0] set_idx,
   input  logic [XE-1:0]    match,
   input  logic [XE-1:0]    vec_q [SETS][WAYS],
   input  logic [WAYS-1:0]  vld_q [SETS],
   output logic [WAYS-1:0]  hit,
   output logic [WAYS-1:0]  corrupt,
   output logic             multi_hit
);
   logic [WAYS-1:0] row_vld;
   assign row_vld = vld_q[set_idx];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      xtag_way_cmp #(.XE(XE), .ONEHOT_CHK(ONEHOT_CHK)) u_cmp (
         .vec     (vec_q[set_idx][w]),
         .vld     (row_vld[w]),
         .match   (match),
         .hit     (hit[w]),
         .corrupt (corrupt[w])
      );
   end

   assign multi_hit = |(hit & (hit - WAYS'(1)));
endmodule

// File: rtl/xtag_store.sv
module xtag_store #(
   parameter int unsigned SETS  = 64,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned XE    = 32,
   parameter int unsigned NP    = 2,
   localparam int unsigned IDX_W = xtag_pkg::idx_w(SETS),
   localparam int unsigned WAY_W = xtag_pkg::idx_w(WAYS),
   localparam int unsigned XI_W  = xtag_pkg::idx_w(XE)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fill_en,
   input  logic [IDX_W-1:0]      fill_set,
   input  logic [WAY_W-1:0]      fill_way,
   input  logic [XE-1:0]         fill_vec,
   input  logic                  drop_en,
   input  logic [IDX_W-1:0]      drop_set,
   input  logic [WAY_W-1:0]      drop_way,
   input  logic                  retire_en,
   input  logic [XI_W-1:0]       retire_idx,
   input  logic [NP*WAYS-1:0]    scrub,
   input  logic [NP*IDX_W-1:0]   scrub_set,
   output logic [XE-1:0]         vec_q [SETS][WAYS],
   output logic [WAYS-1:0]       vld_q [SETS]
);
   logic [XE-1:0] keep_mask;
   assign keep_mask = retire_en ? ~(XE'(1) << retire_idx) : '1;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic wr_here;
         logic drop_here;
         logic [NP-1:0] scrub_here;

         for (genvar p = 0; p < NP; p++) begin : g_port
            assign scrub_here[p] = scrub[p*WAYS + w] &&
                                   (scrub_set[p*IDX_W +: IDX_W] == IDX_W'(s));
         end

         assign wr_here   = fill_en && (fill_set == IDX_W'(s)) && (fill_way == WAY_W'(w));
         assign drop_here = (drop_en && (drop_set == IDX_W'(s)) && (drop_way == WAY_W'(w)))
                            || (|scrub_here);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[s][w] <= 1'b0;
               vec_q[s][w] <= '0;
            end else if (wr_here) begin
               vld_q[s][w] <= 1'b1;
               vec_q[s][w] <= fill_vec;
            end else begin
               vec_q[s][w] <= vec_q[s][w] & keep_mask;
               if (drop_here) vld_q[s][w] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/xtag_array.sv
module xtag_array #(
   parameter int unsigned SETS       = 64,
   parameter int unsigned WAYS       = 4,
   parameter int unsigned XE         = 32,
   parameter int unsigned NP         = 2,
   parameter bit          ONEHOT_CHK = 1'b1,
   localparam int unsigned IDX_W     = xtag_pkg::idx_w(SETS),
   localparam int unsigned WAY_W     = xtag_pkg::idx_w(WAYS),
   localparam int unsigned XI_W      = xtag_pkg::idx_w(XE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fill_en,
   input  logic [IDX_W-1:0]    fill_set,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic [XE-1:0]       fill_vec,
   input  logic                line_drop_en,
   input  logic [IDX_W-1:0]    line_drop_set,
   input  logic [WAY_W-1:0]    line_drop_way,
   input  logic                xlat_retire_en,
   input  logic [XI_W-1:0]     xlat_retire_idx,
   input  logic [NP*IDX_W-1:0] rd_set,
   input  logic [NP*XE-1:0]    rd_match,
   output logic [NP*WAYS-1:0]  rd_hit,
   output logic [NP-1:0]       rd_multi_hit,
   output logic [NP*WAYS-1:0]  rd_corrupt
);
   if (!xtag_pkg::is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("xtag_array: SETS must be a power of two of at least 2");
   end
   if (!xtag_pkg::is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("xtag_array: WAYS must be a power of two of at least 2");
   end
   if (!xtag_pkg::is_pow2(XE) || XE < 2) begin : g_bad_xe
      $error("xtag_array: XE must be a power of two of at least 2");
   end
   if (NP < 1) begin : g_bad_np
      $error("xtag_array: NP must be at least 1");
   end

   logic [XE-1:0]   vec_q [SETS][WAYS];
   logic [WAYS-1:0] vld_q [SETS];

   xtag_store #(.SETS(SETS), .WAYS(WAYS), .XE(XE), .NP(NP)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_en),
      .fill_set   (fill_set),
      .fill_way   (fill_way),
      .fill_vec   (fill_vec),
      .drop_en    (line_drop_en),
      .drop_set   (line_drop_set),
      .drop_way   (line_drop_way),
      .retire_en  (xlat_retire_en),
      .retire_idx (xlat_retire_idx),
      .scrub      (rd_corrupt),
      .scrub_set  (rd_set),
      .vec_q      (vec_q),
      .vld_q      (vld_q)
   );

   for (genvar p = 0; p < NP; p++) begin : g_port
      xtag_rd_port #(.SETS(SETS), .WAYS(WAYS), .XE(XE), .ONEHOT_CHK(ONEHOT_CHK)) u_rd (
         .set_idx   (rd_set[p*IDX_W +: IDX_W]),
         .match     (rd_match[p*XE +: XE]),
         .vec_q     (vec_q),
         .vld_q     (vld_q),
         .hit       (rd_hit[p*WAYS +: WAYS]),
         .corrupt   (rd_corrupt[p*WAYS +: WAYS]),
         .multi_hit (rd_multi_hit[p])
      );
   end
endmodule

// File: rtl/xtag_chk.sv
module xtag_chk #(
   parameter int unsigned SETS  = 64,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned XE    = 32,
   parameter int unsigned NP    = 2,
   localparam int unsigned IDX_W = xtag_pkg::idx_w(SETS),
   localparam int unsigned WAY_W = xtag_pkg::idx_w(WAYS),
   localparam int unsigned XI_W  = xtag_pkg::idx_w(XE)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                fill_en,
   input logic [IDX_W-1:0]    fill_set,
   input logic [WAY_W-1:0]    fill_way,
   input logic                line_drop_en,
   input logic [IDX_W-1:0]    line_drop_set,
   input logic [WAY_W-1:0]    line_drop_way,
   input logic                xlat_retire_en,
   input logic [XI_W-1:0]     xlat_retire_idx,
   input logic [NP*IDX_W-1:0] rd_set,
   input logic [NP*XE-1:0]    rd_match,
   input logic [NP*WAYS-1:0]  rd_hit,
   input logic [NP*WAYS-1:0]  rd_corrupt,
   input logic [WAYS-1:0]     vld [SETS]
);
   // R8
   fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> vld[$past(fill_set)][$past(fill_way)]);

   // R9
   drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_drop_en && !(fill_en && fill_set == line_drop_set && fill_way == line_drop_way))
      |=> !vld[$past(line_drop_set)][$past(line_drop_way)]);

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic [IDX_W-1:0] pset;
      logic [XE-1:0]    pmatch;
      assign pset   = rd_set[p*IDX_W +: IDX_W];
      assign pmatch = rd_match[p*XE +: XE];

      // R7
      retire_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (xlat_retire_en && !fill_en)
         |=> !((pmatch == (XE'(1) << $past(xlat_retire_idx))) && (|rd_hit[p*WAYS +: WAYS])));

      for (genvar w = 0; w < WAYS; w++) begin : g_way
         // R5
         corrupt_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_corrupt[p*WAYS + w] |-> !rd_hit[p*WAYS + w]);

         // R6
         corrupt_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_corrupt[p*WAYS + w] && !(fill_en && fill_set == pset && fill_way == WAY_W'(w)))
            |=> !vld[$past(pset)][w]);
      end
   end
endmodule

bind xtag_array xtag_chk #(.SETS(SETS), .WAYS(WAYS), .XE(XE), .NP(NP)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fill_en         (fill_en),
   .fill_set        (fill_set),
   .fill_way        (fill_way),
   .line_drop_en    (line_drop_en),
   .line_drop_set   (line_drop_set),
   .line_drop_way   (line_drop_way),
   .xlat_retire_en  (xlat_retire_en),
   .xlat_retire_idx (xlat_retire_idx),
   .rd_set          (rd_set),
   .rd_match        (rd_match),
   .rd_hit          (rd_hit),
   .rd_corrupt      (rd_corrupt),
   .vld             (vld_q)
);

// File: tb/xtag_array_tb.sv
module xtag_array_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_en = 1'b0;
   logic [5:0]  fill_set = '0;
   logic [1:0]  fill_way = '0;
   logic [31:0] fill_vec = '0;
   logic        line_drop_en = 1'b0;
   logic [5:0]  line_drop_set = '0;
   logic [1:0]  line_drop_way = '0;
   logic        xlat_retire_en = 1'b0;
   logic [4:0]  xlat_retire_idx = '0;
   logic [11:0] rd_set = '0;
   logic [63:0] rd_match = '0;
   logic [7:0]  rd_hit;
   logic [1:0]  rd_multi_hit;
   logic [7:0]  rd_corrupt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   xtag_array u_dut (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_vec(fill_vec),
      .line_drop_en(line_drop_en), .line_drop_set(line_drop_set), .line_drop_way(line_drop_way),
      .xlat_retire_en(xlat_retire_en), .xlat_retire_idx(xlat_retire_idx),
      .rd_set(rd_set), .rd_match(rd_match),
      .rd_hit(rd_hit), .rd_multi_hit(rd_multi_hit), .rd_corrupt(rd_corrupt)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input int p, input logic [5:0] s, input logic [31:0] m);
      rd_set[p*6 +: 6]    = s;
      rd_match[p*32 +: 32] = m;
   endtask

   task automatic rd_idle();
      rd_set   = '0;
      rd_match = '0;
      #1;
   endtask

   task automatic do_fill(input logic [5:0] s, input logic [1:0] w, input logic [31:0] v);
      fill_en = 1'b1; fill_set = s; fill_way = w; fill_vec = v;
      tick();
      fill_en = 1'b0;
   endtask

   task automatic t_reset();
      rd(0, 6'd0, '1); rd(1, 6'd63, '1); #1;
      check(32'(rd_hit), 0, "R1 reset hit");
      check(32'(rd_corrupt), 0, "R1 reset corrupt");
      check(32'(rd_multi_hit), 0, "R1 reset multi");
      rd_idle();
   endtask

   task automatic t_fill_hit();
      do_fill(6'd5, 2'd2, 32'h0000_0080);
      rd(0, 6'd5, 32'h0000_0080); #1;
      check(32'(rd_hit), 32'h04, "R2 match hit");
      rd(0, 6'd5, 32'h0000_0100); #1;
      check(32'(rd_hit), 32'h00, "R2 other bit no hit");
      rd(0, 6'd5, 32'h0); #1;
      check(32'(rd_hit), 32'h00, "R2 zero match");
      rd(0, 6'd6, 32'h0000_0080); #1;
      check(32'(rd_hit), 32'h00, "R2 other set");
      rd_idle();
      do_fill(6'd5, 2'd2, 32'h0000_0800);
      rd(0, 6'd5, 32'h0000_0080); #1;
      check(32'(rd_hit), 32'h00, "R1 old vector replaced");
      rd(0, 6'd5, 32'h0000_0800); #1;
      check(32'(rd_hit), 32'h04, "R1 new vector hits");
      rd_idle();
   endtask

   task automatic t_ports();
      do_fill(6'd9, 2'd0, 32'h0000_0008);
      rd(0, 6'd9, 32'h0000_0008); rd(1, 6'd5, 32'h0000_0800); #1;
      check(32'(rd_hit), 32'h41, "R3 two ports");
      rd(0, 6'd5, 32'h0000_0800); rd(1, 6'd9, 32'h0000_0010); #1;
      check(32'(rd_hit), 32'h04, "R3 swapped sets");
      rd_idle();
   endtask

   task automatic t_multi();
      do_fill(6'd12, 2'd1, 32'h0000_0010);
      rd(1, 6'd12, 32'h0000_0010); #1;
      check(32'(rd_multi_hit), 32'h0, "R4 single way");
      rd_idle();
      do_fill(6'd12, 2'd3, 32'h0000_0010);
      rd(1, 6'd12, 32'h0000_0010); rd(0, 6'd63, 32'h0); #1;
      check(32'(rd_hit), 32'hA0, "R4 two ways hit");
      check(32'(rd_multi_hit), 32'h2, "R4 multi flag port1");
      rd_idle();
   endtask

   task automatic t_corrupt();
      do_fill(6'd20, 2'd0, 32'h0000_0011);
      rd(0, 6'd20, 32'h0000_0001); #1;
      check(32'(rd_hit), 32'h00, "R5 corrupt way no hit");
      check(32'(rd_corrupt), 32'h01, "R5 corrupt flag");
      tick();
      check(32'(rd_corrupt), 32'h00, "R6 flag gone after scrub");
      check(32'(rd_hit), 32'h00, "R6 scrubbed way no hit");
      rd_idle();
      do_fill(6'd20, 2'd0, 32'h0000_0001);
      rd(0, 6'd20, 32'h0000_0001); #1;
      check(32'(rd_hit), 32'h01, "R6 refill hits");
      rd_idle();
   endtask

   task automatic t_retire();
      do_fill(6'd30, 2'd3, 32'h0000_0200);
      do_fill(6'd31, 2'd1, 32'h0000_0200);
      do_fill(6'd30, 2'd0, 32'h0000_0400);
      xlat_retire_en = 1'b1; xlat_retire_idx = 5'd9;
      tick();
      xlat_retire_en = 1'b0;
      rd(0, 6'd30, 32'h0000_0200); rd(1, 6'd31, 32'h0000_0200); #1;
      check(32'(rd_hit), 32'h00, "R7 retired bit no hit");
      rd(0, 6'd30, 32'h0000_0400); rd(1, 6'd31, 32'h0); #1;
      check(32'(rd_hit), 32'h01, "R7 other entry kept");
      rd_idle();
   endtask

   task automatic t_prio();
      fill_en = 1'b1; fill_set = 6'd40; fill_way = 2'd2; fill_vec = 32'h0000_0020;
      line_drop_en = 1'b1; line_drop_set = 6'd40; line_drop_way = 2'd2;
      tick();
      fill_en = 1'b0; line_drop_en = 1'b0;
      rd(0, 6'd40, 32'h0000_0020); #1;
      check(32'(rd_hit), 32'h04, "R8 fill beats drop");
      rd_idle();
      fill_en = 1'b1; fill_set = 6'd41; fill_way = 2'd1; fill_vec = 32'h0000_0040;
      xlat_retire_en = 1'b1; xlat_retire_idx = 5'd6;
      tick();
      fill_en = 1'b0; xlat_retire_en = 1'b0;
      rd(1, 6'd41, 32'h0000_0040); #1;
      check(32'(rd_hit), 32'h20, "R8 fill beats retire");
      rd_idle();
      do_fill(6'd42, 2'd0, 32'h0000_0003);
      rd(0, 6'd42, 32'h0000_0004);
      fill_en = 1'b1; fill_set = 6'd42; fill_way = 2'd0; fill_vec = 32'h0000_0004;
      #1;
      check(32'(rd_corrupt), 32'h01, "R8 corrupt seen before fill");
      tick();
      fill_en = 1'b0;
      #1;
      check(32'(rd_hit), 32'h01, "R8 fill beats scrub");
      check(32'(rd_corrupt), 32'h00, "R8 no corrupt after fill");
      rd_idle();
   endtask

   task automatic t_drop();
      do_fill(6'd40, 2'd1, 32'h0000_0020);
      line_drop_en = 1'b1; line_drop_set = 6'd40; line_drop_way = 2'd2;
      tick();
      line_drop_en = 1'b0;
      rd(0, 6'd40, 32'h0000_0020); #1;
      check(32'(rd_hit), 32'h02, "R9 dropped way gone, neighbour kept");
      rd_idle();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_fill_hit();
      t_ports();
      t_multi();
      t_corrupt();
      t_retire();
      t_prio();
      t_drop();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule